// File: doc/BRIEF.md
# Serial Receiver with Two-Entry Receive Queue

This block turns an asynchronous serial line into bytes for a host. It oversamples the line at sixteen ticks per bit and checks that a falling edge is a real start bit. It then decides each data, parity and stop bit by majority vote, and writes each finished character into a two-entry queue. Each queue entry holds the byte along with its own frame-error, parity-error and overrun marks. Those marks therefore always belong to the character the host reads next, and never to the character most recently received.

The host has three controls: a receiver enable, a parity-check enable and a one-cycle pop strobe. Dropping the enable empties the queue and returns the line decoder to idle. When the queue is full, a third completed character waits in the decoder. If a fourth start bit is confirmed before a queue slot frees, that waiting character is discarded. The next character stored is then marked as overrun.

Top module: `uart_rx_fifo2`

## Requirements
- R1: The queue holds two characters. Each pop of a non-empty queue removes exactly the head entry, and characters leave in arrival order.
- R2: `rx_ready` is 1 exactly when at least one unread character is queued, and 0 when the queue is empty.
- R3: While `rx_en` is 0, the queue is flushed from the next clock on, `rx_ready` reads 0, and any partly received or waiting character is discarded.
- R4: A frame is one low start bit, eight data bits sent least significant bit first, one parity bit only when parity checking was enabled at the start of the frame, and one stop bit. The byte appears on `rd_data` while it is at the head of the queue.
- R5: A low pulse that has ended by the middle of the start bit (sample 7 of 16) is ignored, and no character is produced.
- R6: Every data, parity and stop bit is decided by a majority of samples 7, 8 and 9. A wrong value on one of these samples does not change the result.
- R7: `err_frame` is 1 for the head character when its stop bit was decided as 0, and 0 when it was 1. The character is stored either way.
- R8: `err_parity` is 1 for the head character only if parity checking was enabled when that character's start bit arrived and the data bits together with the parity bit have an odd number of ones (even parity). Changing `par_en` later does not alter the mark of a stored character.
- R9: If the queue is full, a completed character is waiting in the decoder, and a new start bit is confirmed, then the waiting character is dropped and the queued characters are kept. The next character written into the queue carries `err_overrun` = 1.
- R10: A character waiting in the decoder enters the queue, without an overrun mark, as soon as a pop frees a slot.
- R11: A pop on an empty queue changes no state, and `rd_data` keeps the value of the last character popped.
- R12: `err_frame`, `err_parity` and `err_overrun` describe only the head character, and all three read 0 while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; 0 flushes and idles the receiver |
| par_en | input | 1 | Parity bit present and checked in frames that start while this is 1 |
| rxd | input | 1 | Serial line, idle high |
| rd_pop | input | 1 | One-cycle strobe that removes the head character |
| rd_data | output | 8 | Head character, or the last popped character when empty |
| rx_ready | output | 1 | At least one unread character is queued |
| err_frame | output | 1 | Head character had a zero stop bit |
| err_parity | output | 1 | Head character failed the enabled parity check |
| err_overrun | output | 1 | A character was lost just before the head character |

## Verification
The bench builds the block with `CLKS_PER_TICK` = 2, which makes a bit 32 clocks long. At that length, more than twenty whole frames fit easily within the run, including the four-frame sequence that fills the queue, holds a character in the decoder and then drops it. The queue depth and the parity sense stay at their defaults, 2 and even. With depth 2, three frames are enough to reach the full and waiting states. The short tick also lets the bench place a one-tick glitch on a single vote sample, and a start pulse shorter than half a bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int RX_DATA_W = 8;
  localparam int RX_OSR    = 16;
  localparam int RX_SMP_W  = $clog2(RX_OSR);
  localparam int RX_MID    = RX_OSR / 2 - 1;
  localparam int RX_LAST   = RX_OSR - 1;

  typedef struct packed {
    logic                 ovr;
    logic                 pe;
    logic                 fe;
    logic [RX_DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int CLKS_PER_TICK = 54
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [CW-1:0] TOP = CW'(CLKS_PER_TICK - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter bit PAR_ODD = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      tick,
  input  logic      rxd,
  input  logic      par_en,
  input  logic      accept,
  output logic      frm_valid,
  output rx_entry_t frm,
  output logic      ovr_evt
);

  localparam int BCW = $clog2(RX_DATA_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(RX_DATA_W - 1);
  localparam logic [RX_SMP_W-1:0] S_MID  = RX_SMP_W'(RX_MID);
  localparam logic [RX_SMP_W-1:0] S_MID1 = RX_SMP_W'(RX_MID + 1);
  localparam logic [RX_SMP_W-1:0] S_MID2 = RX_SMP_W'(RX_MID + 2);
  localparam logic [RX_SMP_W-1:0] S_LAST = RX_SMP_W'(RX_LAST);

  logic                 sync1_q, sync2_q;
  rx_state_e            st_q, st_d;
  logic [RX_SMP_W-1:0]  smp_q, smp_d, idx;
  logic [BCW-1:0]       bit_q, bit_d;
  logic [RX_DATA_W-1:0] sh_q, sh_d;
  logic [1:0]           vote_q, vote_d;
  logic                 parlat_q, parlat_d;
  logic                 parbit_q, parbit_d;
  logic                 hold_q, hold_d;
  logic                 hfe_q, hfe_d;
  logic                 hpe_q, hpe_d;
  logic [RX_DATA_W-1:0] hdat_q, hdat_d;
  logic                 pend_q, pend_d;
  logic                 start_ok, maj;

  assign idx = smp_q + 1'b1;
  assign maj = (vote_q[1] & vote_q[0]) | (vote_q[1] & sync2_q) | (vote_q[0] & sync2_q);

  always_comb begin
    st_d     = st_q;
    smp_d    = smp_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    vote_d   = vote_q;
    parlat_d = parlat_q;
    parbit_d = parbit_q;
    hold_d   = hold_q;
    hfe_d    = hfe_q;
    hpe_d    = hpe_q;
    hdat_d   = hdat_q;
    pend_d   = pend_q;
    start_ok = 1'b0;
    if (accept) begin
      hold_d = 1'b0;
      pend_d = 1'b0;
    end
    if (!en) begin
      st_d   = RX_IDLE;
      smp_d  = '0;
      hold_d = 1'b0;
      pend_d = 1'b0;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!sync2_q) begin
            st_d     = RX_START;
            smp_d    = '0;
            parlat_d = par_en;
          end
        end
        RX_START: begin
          smp_d = idx;
          if (idx == S_MID) begin
            if (sync2_q) st_d = RX_IDLE;
            else         start_ok = 1'b1;
          end else if (idx == S_LAST) begin
            st_d  = RX_DATA;
            bit_d = '0;
          end
        end
        default: begin
          smp_d = idx;
          if (idx == S_MID || idx == S_MID1) vote_d = {vote_q[0], sync2_q};
          if (idx == S_MID2) begin
            case (st_q)
              RX_DATA: sh_d = {maj, sh_q[RX_DATA_W-1:1]};
              RX_PAR:  parbit_d = maj;
              default: begin
                hold_d = 1'b1;
                hfe_d  = !maj;
                hpe_d  = parlat_q & ((^sh_q) ^ parbit_q ^ PAR_ODD);
                hdat_d = sh_q;
                st_d   = RX_IDLE;
              end
            endcase
          end
          if (idx == S_LAST) begin
            case (st_q)
              RX_DATA: begin
                if (bit_q == LAST_BIT) st_d = parlat_q ? RX_PAR : RX_STOP;
                else                   bit_d = bit_q + 1'b1;
              end
              RX_PAR:  st_d = RX_STOP;
              default: st_d = st_q;
            endcase
          end
        end
      endcase
    end
    if (start_ok && hold_q && !accept) begin
      hold_d = 1'b0;
      pend_d = 1'b1;
    end
  end

  assign ovr_evt   = start_ok && hold_q && !accept;
  assign frm_valid = hold_q;
  assign frm       = '{ovr: pend_q, pe: hpe_q, fe: hfe_q, data: hdat_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q  <= 1'b1;
      sync2_q  <= 1'b1;
      st_q     <= RX_IDLE;
      smp_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      vote_q   <= '0;
      parlat_q <= 1'b0;
      parbit_q <= 1'b0;
      hold_q   <= 1'b0;
      hfe_q    <= 1'b0;
      hpe_q    <= 1'b0;
      hdat_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      sync1_q  <= rxd;
      sync2_q  <= sync1_q;
      st_q     <= st_d;
      smp_q    <= smp_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      vote_q   <= vote_d;
      parlat_q <= parlat_d;
      parbit_q <= parbit_d;
      hold_q   <= hold_d;
      hfe_q    <= hfe_d;
      hpe_q    <= hpe_d;
      hdat_q   <= hdat_d;
      pend_q   <= pend_d;
    end
  end

  // R9: a dropped character leaves the holding slot empty and arms the mark
  p_drop_arms_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> (pend_q && !hold_q));

  // R3: a disabled receiver returns to idle with nothing waiting
  p_idle_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_q == RX_IDLE && !hold_q && !pend_q));

  // R5: a start that fails the mid-bit check produces no frame
  p_false_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && st_q == RX_START && idx == S_MID && sync2_q) |=> st_q == RX_IDLE);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 push,
  input  rx_entry_t            push_ent,
  input  logic                 pop,
  output rx_entry_t            head,
  output logic                 empty,
  output logic                 full,
  output logic [RX_DATA_W-1:0] last_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PTR_TOP = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  rx_entry_t            mem_q [DEPTH];
  logic [PW-1:0]        wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [RX_DATA_W-1:0] last_q, last_d;
  logic                 pop_eff, push_eff;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_MAX);
  assign pop_eff  = pop && !empty && !flush;
  assign push_eff = push && !flush && (!full || pop_eff);
  assign head     = mem_q[rd_q];
  assign last_data = last_q;

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_eff) wr_d = (wr_q == PTR_TOP) ? '0 : wr_q + 1'b1;
      if (pop_eff) begin
        rd_d   = (rd_q == PTR_TOP) ? '0 : rd_q + 1'b1;
        last_d = head.data;
      end
      case ({push_eff, pop_eff})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_eff) mem_q[wr_q] <= push_ent;
  end

  // R1: occupancy never exceeds the depth
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R1: a lone pop of a non-empty queue removes one entry
  p_pop_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push && !flush) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R11: a pop on an empty queue leaves every piece of state alone
  p_empty_pop_still_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> (empty && $stable(last_q) && $stable(rd_q)));

endmodule

// File: rtl/uart_rx_fifo2.sv
module uart_rx_fifo2
  import uart_rx_pkg::*;
#(
  parameter int CLKS_PER_TICK = 54,
  parameter int FIFO_DEPTH    = 2,
  parameter bit PAR_ODD       = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 par_en,
  input  logic                 rxd,
  input  logic                 rd_pop,
  output logic [RX_DATA_W-1:0] rd_data,
  output logic                 rx_ready,
  output logic                 err_frame,
  output logic                 err_parity,
  output logic                 err_overrun
);

  logic                 tick;
  logic                 frm_valid, ovr_evt, accept;
  rx_entry_t            frm, head;
  logic                 empty, full;
  logic [RX_DATA_W-1:0] last_data;

  uart_rx_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) i_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (rx_en),
    .tick (tick)
  );

  uart_rx_deframer #(.PAR_ODD(PAR_ODD)) i_deframer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .tick     (tick),
    .rxd      (rxd),
    .par_en   (par_en),
    .accept   (accept),
    .frm_valid(frm_valid),
    .frm      (frm),
    .ovr_evt  (ovr_evt)
  );

  assign accept = rx_en && frm_valid && (!full || (rd_pop && !empty));

  uart_rx_queue #(.DEPTH(FIFO_DEPTH)) i_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (!rx_en),
    .push     (accept),
    .push_ent (frm),
    .pop      (rd_pop),
    .head     (head),
    .empty    (empty),
    .full     (full),
    .last_data(last_data)
  );

  assign rx_ready    = !empty;
  assign rd_data     = empty ? last_data : head.data;
  assign err_frame   = !empty && head.fe;
  assign err_parity  = !empty && head.pe;
  assign err_overrun = !empty && head.ovr;

  // R3: the queue reads empty one clock after the receiver is disabled
  p_flush_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_ready);

  // R12: no error mark is visible without a head character
  p_flags_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> !(err_frame || err_parity || err_overrun));

  // R9: a character is dropped only while the queue is full
  p_drop_only_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> full);

endmodule

// File: tb/test_uart_rx_fifo2.sv
module test_uart_rx_fifo2;

  localparam int CLK_PERIOD = 10;
  localparam int CPT        = 2;
  localparam int BITCLK     = 16 * CPT;

  logic       clk = 1'b0;
  logic       rst_n, rx_en, par_en, rxd, rd_pop;
  logic [7:0] rd_data;
  logic       rx_ready, err_frame, err_parity, err_overrun;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_fifo2 #(.CLKS_PER_TICK(CPT)) i_uart_rx_fifo2 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .par_en(par_en), .rxd(rxd),
    .rd_pop(rd_pop), .rd_data(rd_data), .rx_ready(rx_ready),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
  );

  // {data[12:5], par_en[4], flip_par[3], stop[2], exp_fe[1], exp_pe[0]}
  localparam logic [12:0] VEC [0:5] = '{
    {8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit wp, input bit flip,
                      input bit stopv, input int gl_bit);
    int nb;
    nb = wp ? 11 : 10;
    for (int b = 0; b < nb; b++) begin
      logic v;
      if (b == 0)             v = 1'b0;
      else if (b <= 8)        v = d[b-1];
      else if (wp && b == 9)  v = (^d) ^ flip;
      else                    v = stopv;
      for (int s = 0; s < 16; s++) begin
        rxd = (b == gl_bit && s == 9) ? ~v : v;
        repeat (CPT) @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; par_en = 1'b0; rxd = 1'b1; rd_pop = 1'b0;
    repeat (4) @(negedge clk);
    // reset state (R2, R12)
    chk("R2 ready after reset", rx_ready, 0);
    chk("R11 data after reset", rd_data, 0);
    chk("R12 flags after reset", {err_frame, err_parity, err_overrun}, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (BITCLK) @(negedge clk);

    // table of single frames (R4, R7, R8, R2, R1)
    for (int i = 0; i < 6; i++) begin
      logic [12:0] v;
      v = VEC[i];
      par_en = v[4];
      send(v[12:5], v[4], v[3], v[2], -1);
      chk("R2 ready after frame", rx_ready, 1);
      chk("R4 data", rd_data, v[12:5]);
      chk("R7 frame error", err_frame, v[1]);
      chk("R8 parity error", err_parity, v[0]);
      pop();
      chk("R1 empty after single pop", rx_ready, 0);
    end
    par_en = 1'b0;

    // R5: short low pulse
    rxd = 1'b0;
    repeat (4 * CPT) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk("R5 short pulse ignored", rx_ready, 0);

    // R6: single-sample glitch on data bit 3 and on the stop bit
    send(8'h00, 1'b0, 1'b0, 1'b1, 4);
    chk("R6 glitch on data bit", rd_data, 8'h00);
    pop();
    send(8'h5A, 1'b0, 1'b0, 1'b1, 9);
    chk("R6 glitch on stop bit", err_frame, 0);
    chk("R6 data beside stop glitch", rd_data, 8'h5A);
    pop();

    // R10: third character waits, then enters after a pop
    send(8'h11, 1'b0, 1'b0, 1'b1, -1);
    send(8'h22, 1'b0, 1'b0, 1'b1, -1);
    send(8'h33, 1'b0, 1'b0, 1'b1, -1);
    chk("R1 head is oldest", rd_data, 8'h11);
    pop();
    chk("R1 second in order", rd_data, 8'h22);
    pop();
    chk("R10 waiting char delivered", rd_data, 8'h33);
    chk("R10 no overrun mark", err_overrun, 0);
    pop();
    chk("R1 empty after three pops", rx_ready, 0);

    // R9: fourth start while full and holding
    send(8'h44, 1'b0, 1'b0, 1'b1, -1);
    send(8'h55, 1'b0, 1'b0, 1'b1, -1);
    send(8'h66, 1'b0, 1'b0, 1'b1, -1);
    send(8'h77, 1'b0, 1'b0, 1'b1, -1);
    chk("R9 queue kept head", rd_data, 8'h44);
    chk("R9 no mark on old head", err_overrun, 0);
    pop();
    chk("R9 queue kept second", rd_data, 8'h55);
    chk("R9 no mark on second", err_overrun, 0);
    pop();
    chk("R9 dropped char skipped", rd_data, 8'h77);
    chk("R9 mark on next stored", err_overrun, 1);
    pop();
    chk("R12 flags clear when empty", err_overrun, 0);

    // R11: pops on empty queue
    chk("R11 last data held", rd_data, 8'h77);
    pop();
    chk("R11 empty pop keeps data", rd_data, 8'h77);
    chk("R11 empty pop keeps empty", rx_ready, 0);
    send(8'h99, 1'b0, 1'b0, 1'b1, -1);
    chk("R11 next char unaffected", rd_data, 8'h99);
    pop();

    // R8: mark latched with the character
    par_en = 1'b1;
    send(8'h3C, 1'b1, 1'b1, 1'b1, -1);
    par_en = 1'b0;
    @(negedge clk);
    chk("R8 mark survives enable change", err_parity, 1);
    pop();
    chk("R12 parity mark gone when empty", err_parity, 0);

    // R12: marks follow the head only
    send(8'hC3, 1'b0, 1'b0, 1'b0, -1);
    send(8'h3C, 1'b0, 1'b0, 1'b1, -1);
    chk("R12 head frame mark", err_frame, 1);
    pop();
    chk("R12 next head clean", err_frame, 0);
    chk("R12 next head data", rd_data, 8'h3C);
    pop();

    // R3: disable flushes
    send(8'hA1, 1'b0, 1'b0, 1'b1, -1);
    chk("R3 ready before disable", rx_ready, 1);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R3 flushed", rx_ready, 0);
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 stays empty on re-enable", rx_ready, 0);
    send(8'hB2, 1'b0, 1'b0, 1'b1, -1);
    chk("R3 fresh char after flush", rd_data, 8'hB2);
    pop();
    chk("R3 old char gone", rx_ready, 0);

    done = 1'b1;
    finish_run();
  end

endmodule